// File: doc/BRIEF.md
# I2C Target with Restart Recovery

This block is a bus target for a two-wire serial bus. It samples the clock and data lines with the system clock, recognises Start, Repeated Start and Stop, and compares a 7-bit address against a host-supplied value. Write bytes reach the host on a parallel port with a one-cycle strobe. Read bytes come from a holding register that the host fills. The block drives the data line low (open drain) to acknowledge a byte or to send a zero.

A Start is honoured in every state once the block is enabled. A Start that arrives inside a byte discards the partial byte, and a Start between two read addressings begins a clean new read. A watchdog restarts at every Start and returns the target to idle when no Stop follows within a programmable number of cycles. Clearing the enable input, or moving the mode field away from the target code, acts as a soft reset of the protocol logic.

Top module: `i2c_tgt_top`

## Requirements
- R1: `start_flag` rises after a Start (SDA falls while SCL is high) and falls after a Stop (SDA rises while SCL is high).
- R2: The first byte after a Start is taken MSB first on SCL rising edges. Its upper 7 bits are the address and bit 0 is the direction, where 1 means read. On a match the target pulls SDA low for the ninth clock. On a mismatch it leaves SDA released for the rest of the transfer.
- R3: In a write transfer each data byte is acknowledged. `rx_data` then takes the byte and `rx_valid` is high for exactly one cycle.
- R4: In a read transfer the target shifts out the value last latched by `tx_load`, MSB first. A master ACK reloads the next byte from the holding register. A master NACK releases SDA until the next Start or Stop.
- R5: A Start inside a byte discards the bits received so far, produces no `rx_valid`, and returns the target to the address phase.
- R6: A Repeated Start between two read addressings of this target, each ended by a master NACK, yields a correct second read.
- R7: An address NACK from the target does not clear `start_flag`, and a later Repeated Start with a matching address is served.
- R8: When `tmo_limit` is L and not 0, `tmo_pulse` is high for one cycle L cycles after `start_flag` rises, unless a Stop or a new Start comes first. At that pulse the target goes idle, releases SDA and clears `start_flag`. When L is 0 no timeout occurs.
- R9: While `en` is 0 the target is idle: SDA is released and `start_flag` is 0. After `en` returns to 1, clock pulses without a Start are not acknowledged.
- R10: While `mode` differs from the target code (default 4'h6), the target behaves as in R9.
- R11: `sda_oe` only rises while SCL is low.
- R12: After reset `sda_oe`, `start_flag`, `rx_valid` and `tmo_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| en | input | 1 | Block enable; 0 holds the protocol logic idle |
| mode | input | MODE_W | Operating mode; only SLAVE_MODE is active |
| own_addr | input | ADDR_W | Address this target answers |
| tmo_limit | input | TMO_W | Watchdog length in cycles; 0 disables it |
| tx_data | input | DATA_W | Next read byte from the host |
| tx_load | input | 1 | Latches tx_data into the holding register |
| rx_data | output | DATA_W | Last written byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| start_flag | output | 1 | A transfer is open (Start seen, no Stop yet) |
| tmo_pulse | output | 1 | One-cycle pulse when the watchdog expires |

## Verification
The case that matters most is a data bit being sampled just before the restart that aborts its byte. A Start inside a write byte always comes right after an SCL rising edge, which shifts one more bit into the partial byte. The bench provokes this by issuing a Repeated Start four bits into a data byte. It then checks that no strobe was produced and that the next addressed write delivers exactly one correct byte. The watchdog expiring while the state machine is in the middle of a byte is the second such pairing. That case is judged by the exact pulse cycle and by the idle state afterwards.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK,
      ST_WAIT
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_lines.sv
module i2c_tgt_lines #(
   parameter int NL     = 2,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NL-1:0] din,
   output logic [NL-1:0] lvl,
   output logic [NL-1:0] rise,
   output logic [NL-1:0] fall
);
   if (STAGES < 2) begin : g_bad
      $error("i2c_tgt_lines: STAGES must be at least 2");
   end

   for (genvar g = 0; g < NL; g++) begin : g_line
      logic [STAGES:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[STAGES-1:0], din[g]};
      end
      assign lvl[g]  = pipe[STAGES-1];
      assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
      assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
   end
endmodule

// File: rtl/i2c_tgt_wdog.sv
module i2c_tgt_wdog #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         arm,
   input  logic [W-1:0] limit,
   output logic         fire
);
   if (W < 2) begin : g_bad
      $error("i2c_tgt_wdog: W must be at least 2");
   end

   logic [W-1:0] cnt;
   logic         armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; armed <= 1'b0; fire <= 1'b0;
      end else if (clr) begin
         cnt <= '0; armed <= 1'b0; fire <= 1'b0;
      end else if (arm) begin
         cnt <= '0; armed <= 1'b1; fire <= 1'b0;
      end else if (armed && limit != '0) begin
         if (cnt == limit - 1'b1) begin
            fire <= 1'b1; armed <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1; fire <= 1'b0;
         end
      end else begin
         fire <= 1'b0;
      end
   end

   AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(armed)); // R8
   AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire); // R8
   AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0) |=> !fire); // R8
endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
   import i2c_tgt_pkg::*;
#(
   parameter int              DATA_W      = 8,
   parameter int              ADDR_W      = 7,
   parameter int              SYNC_STAGES = 2,
   parameter int              TMO_W       = 16,
   parameter int              MODE_W      = 4,
   parameter logic [MODE_W-1:0] SLAVE_MODE = 4'h6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              en,
   input  logic [MODE_W-1:0] mode,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              start_flag,
   output logic              tmo_pulse
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (DATA_W != ADDR_W + 1) begin : g_bad_w
      $error("i2c_tgt_top: address plus direction must fill one byte");
   end

   logic [1:0] lv, rs, fl;
   i2c_tgt_lines #(.NL(2), .STAGES(SYNC_STAGES)) u_lines (
      .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}),
      .lvl(lv), .rise(rs), .fall(fl)
   );
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   assign scl_lvl   = lv[1];
   assign sda_lvl   = lv[0];
   assign scl_rise  = rs[1];
   assign scl_fall  = fl[1];
   assign start_det = fl[0] & scl_lvl;
   assign stop_det  = rs[0] & scl_lvl;

   logic soft_rst, tmo_fire, abort;
   assign soft_rst = !en || (mode != SLAVE_MODE);

   i2c_tgt_wdog #(.W(TMO_W)) u_wdog (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst | stop_det),
      .arm(start_det), .limit(tmo_limit), .fire(tmo_fire)
   );
   assign tmo_pulse = tmo_fire;
   assign abort     = soft_rst | tmo_fire;

   logic [DATA_W-1:0] txbuf;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       txbuf <= '0;
      else if (tx_load) txbuf <= tx_data;
   end

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-2:0] sh_rx;
   logic [DATA_W-1:0] sh_tx;
   logic              ack_on, mack, rw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cnt <= '0; sh_rx <= '0; sh_tx <= '0;
         sda_oe <= 1'b0; ack_on <= 1'b0; mack <= 1'b0; rw <= 1'b0;
         rx_data <= '0; rx_valid <= 1'b0; start_flag <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (abort) begin
            state <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0;
            ack_on <= 1'b0; start_flag <= 1'b0;
         end else if (start_det) begin
            state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
            ack_on <= 1'b0; start_flag <= 1'b1;
         end else if (stop_det) begin
            state <= ST_IDLE; sda_oe <= 1'b0;
            ack_on <= 1'b0; start_flag <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WR: if (scl_rise) begin
                  sh_rx <= {sh_rx[DATA_W-3:0], sda_lvl};
                  if (cnt == LAST) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        rw    <= sda_lvl;
                        state <= (sh_rx == own_addr) ? ST_AACK : ST_WAIT;
                     end else begin
                        rx_data  <= {sh_rx, sda_lvl};
                        rx_valid <= 1'b1;
                        state    <= ST_WACK;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_AACK, ST_WACK: if (scl_fall) begin
                  if (!ack_on) begin
                     sda_oe <= 1'b1; ack_on <= 1'b1;
                  end else begin
                     ack_on <= 1'b0;
                     if (state == ST_AACK && rw) begin
                        state  <= ST_RD;
                        sh_tx  <= txbuf;
                        sda_oe <= ~txbuf[DATA_W-1];
                     end else begin
                        state  <= ST_WR;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     if (cnt == LAST) begin
                        cnt <= '0; state <= ST_RACK;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  if (scl_fall) begin
                     sh_tx  <= sh_tx << 1;
                     sda_oe <= ~sh_tx[DATA_W-2];
                  end
               end
               ST_RACK: begin
                  if (scl_rise && ack_on) mack <= ~sda_lvl;
                  if (scl_fall) begin
                     if (!ack_on) begin
                        sda_oe <= 1'b0; ack_on <= 1'b1;
                     end else begin
                        ack_on <= 1'b0;
                        if (mack) begin
                           state  <= ST_RD;
                           sh_tx  <= txbuf;
                           sda_oe <= ~txbuf[DATA_W-1];
                        end else begin
                           state <= ST_WAIT;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (start_det && !tmo_fire) |=> (state == ST_ADDR && cnt == '0)); // R5
   AST_START_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !rx_valid); // R5
   AST_STOP_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !start_flag); // R1
   AST_OE_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl); // R11
   AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (state == ST_IDLE && !sda_oe && !start_flag)); // R9
   AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_fire |=> (!start_flag && !sda_oe)); // R8
   AST_NACK_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> start_flag); // R7
   AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R3
endmodule

// File: tb/tb_i2c_tgt_top.sv
`timescale 1ns/1ps
module tb_i2c_tgt_top;
   localparam logic [6:0] OWN = 7'h3A;
   localparam int Q = 8;
   localparam logic [15:0] VEC [0:5] = '{
      {7'h3A, 8'hA5, 1'b1}, {7'h3A, 8'h00, 1'b1}, {7'h3A, 8'hFF, 1'b1},
      {7'h3B, 8'h5C, 1'b0}, {7'h1A, 8'h33, 1'b0}, {7'h3A, 8'h81, 1'b1}
   };

   logic clk = 0, rst_n = 0;
   logic scl_m = 1, sda_m = 1, en = 1, tx_load = 0;
   logic [3:0]  mode = 4'h6;
   logic [15:0] tmo_limit = '0;
   logic [7:0]  tx_data = '0;
   logic        sda_oe, rx_valid, start_flag, tmo_pulse;
   logic [7:0]  rx_data;
   int checks = 0, fails = 0;
   int cyc = 0, rx_cnt = 0, tmo_cnt = 0, oe_viol = 0, t_sf = 0, t_tmo = 0;
   logic [7:0] last_rx = '0;
   logic oe_q = 0, sf_q = 0;

   always #2.5 clk = ~clk;

   i2c_tgt_top dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_m & ~sda_oe),
      .sda_oe(sda_oe), .en(en), .mode(mode), .own_addr(OWN),
      .tmo_limit(tmo_limit), .tx_data(tx_data), .tx_load(tx_load),
      .rx_data(rx_data), .rx_valid(rx_valid), .start_flag(start_flag),
      .tmo_pulse(tmo_pulse)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rx_valid) begin rx_cnt <= rx_cnt + 1; last_rx <= rx_data; end
      if (tmo_pulse) begin tmo_cnt <= tmo_cnt + 1; t_tmo <= cyc; end
      if (start_flag && !sf_q) t_sf <= cyc;
      sf_q <= start_flag;
      oe_q <= sda_oe;
      if (sda_oe && !oe_q && scl_m) oe_viol <= oe_viol + 1;
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic qw(); repeat (Q) @(negedge clk); endtask
   task automatic m_start();
      sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw();
   endtask
   task automatic m_stop();
      sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw();
   endtask
   task automatic m_bit(input logic b, output logic r);
      sda_m = b; qw(); scl_m = 1; qw(); r = sda_m & ~sda_oe; qw(); scl_m = 0; qw();
   endtask
   task automatic m_byte(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(d[i], r);
      m_bit(1'b1, r);
      ack = ~r;
   endtask
   task automatic m_rd(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
      m_bit(~give_ack, r);
   endtask
   task automatic load(input logic [7:0] v);
      @(negedge clk); tx_data = v; tx_load = 1; @(negedge clk); tx_load = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic ak, r;
      logic [7:0] d;
      int n0;
      repeat (4) @(negedge clk);
      // R12 reset state
      chk("R12 oe", sda_oe, 0); chk("R12 flag", start_flag, 0);
      chk("R12 rxv", rx_valid, 0); chk("R12 tmo", tmo_pulse, 0);
      rst_n = 1; repeat (4) @(negedge clk);

      // vector table: R1 R2 R3
      for (int i = 0; i < 6; i++) begin
         logic [6:0] a; logic [7:0] dv; logic e;
         {a, dv, e} = VEC[i];
         n0 = rx_cnt;
         m_start();
         chk("R1 flag set", start_flag, 1);
         m_byte({a, 1'b0}, ak); chk("R2 addr ack", ak, e);
         m_byte(dv, ak);        chk("R3 data ack", ak, e);
         m_stop(); qw();
         chk("R1 flag clear", start_flag, 0);
         chk("R3 strobes", rx_cnt - n0, e);
         if (e) chk("R3 data", last_rx, dv);
      end
      chk("R8 zero limit no timeout", tmo_cnt, 0);
      chk("R11 oe rise with SCL low", oe_viol, 0);

      // R5 start inside a write byte
      n0 = rx_cnt;
      m_start(); m_byte({OWN, 1'b0}, ak);
      m_bit(1, r); m_bit(0, r); m_bit(1, r); m_bit(1, r);
      m_start();
      chk("R5 no strobe on abort", rx_cnt - n0, 0);
      m_byte({OWN, 1'b0}, ak); chk("R5 readdress ack", ak, 1);
      m_byte(8'h6C, ak); m_stop(); qw();
      chk("R5 one strobe", rx_cnt - n0, 1);
      chk("R5 data", last_rx, 8'h6C);

      // R4 R6 reads with back-to-back read addressing
      load(8'hC3);
      m_start(); m_byte({OWN, 1'b1}, ak); chk("R4 read addr ack", ak, 1);
      load(8'h5A);
      m_rd(1'b1, d); chk("R4 first byte", d, 8'hC3);
      m_rd(1'b0, d); chk("R4 second byte", d, 8'h5A);
      chk("R4 released after NACK", sda_oe, 0);
      load(8'h96);
      m_start(); m_byte({OWN, 1'b1}, ak); chk("R6 second read ack", ak, 1);
      m_rd(1'b0, d); chk("R6 second read data", d, 8'h96);
      m_stop(); qw();

      // R7 target NACK then restart
      n0 = rx_cnt;
      m_start(); m_byte({7'h11, 1'b0}, ak); chk("R7 nack", ak, 0);
      chk("R7 flag kept", start_flag, 1);
      m_start(); m_byte({OWN, 1'b0}, ak); chk("R7 restart ack", ak, 1);
      m_byte(8'h42, ak); m_stop(); qw();
      chk("R7 data", last_rx, 8'h42); chk("R7 strobes", rx_cnt - n0, 1);

      // R8 timeout
      tmo_limit = 16'd1000;
      m_start(); m_byte({OWN, 1'b0}, ak);
      for (int k = 0; k < 3000 && tmo_cnt == 0; k++) @(negedge clk);
      chk("R8 pulse count", tmo_cnt, 1);
      chk("R8 pulse delay", t_tmo - t_sf, 1000);
      chk("R8 flag cleared", start_flag, 0);
      chk("R8 released", sda_oe, 0);
      m_stop(); qw(); tmo_limit = '0;

      // R9 enable clear
      n0 = rx_cnt;
      m_start(); m_byte({OWN, 1'b0}, ak);
      m_bit(1, r); m_bit(1, r); m_bit(0, r);
      en = 0; repeat (3) @(negedge clk);
      chk("R9 flag", start_flag, 0); chk("R9 oe", sda_oe, 0);
      en = 1; @(negedge clk);
      m_byte(8'hE7, ak); chk("R9 no ack without start", ak, 0);
      m_stop(); qw(); chk("R9 no strobe", rx_cnt - n0, 0);

      // R10 mode change
      m_start(); m_byte({OWN, 1'b0}, ak);
      m_bit(0, r); m_bit(1, r);
      mode = 4'h0; repeat (3) @(negedge clk);
      chk("R10 flag", start_flag, 0); chk("R10 oe", sda_oe, 0);
      mode = 4'h6; @(negedge clk);
      m_byte(8'h18, ak); chk("R10 no ack without start", ak, 0);
      m_stop(); qw(); chk("R10 no strobe", rx_cnt - n0, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule